// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM whose data bus can change direction on every cycle without an idle slot. Address, control and byte-lane enables are taken on a rising clock edge. The matching data transfer happens two enabled edges later. At that edge a write takes its word from the data input, and a read puts its word on the output register. A two-stage pipeline holds up to two accesses in flight. A read can therefore follow a write, or a write follow a read, on consecutive cycles.

Three chip selects of mixed polarity gate the start of a new access. A load/advance strobe chooses between taking a fresh address and stepping an internal two-bit burst counter. The burst wraps over an aligned group of four words, in either linear or interleaved order. An active-low clock enable freezes the whole block. An asynchronous active-low output enable can pull the bus driver off at any moment. The shared bidirectional data bus appears as separate input, output and drive-enable ports.

Top module: `zbt_sram`

## Requirements
- R1: A read whose address is sampled at an enabled edge drives `dataDrive` high and presents the stored word on `dataOut` after the second enabled edge that follows.
- R2: A write updates only the lanes whose `laneWrN` bit was low when its address was sampled. Lane k is bits [9k+8:9k] with the default lane width. Other lanes keep their contents.
- R3: Reads and writes may alternate on every cycle, with no idle cycle. A write stores the `dataIn` value present at the second enabled edge after its address edge.
- R4: While `clkEnN` is high, all synchronous inputs are ignored and every register holds. This includes pending accesses, the burst counter and `dataOut`.
- R5: A new access starts only at an enabled edge where `advanceNotLoad` is 0, `selAN` is 0, `selB` is 1 and `selCN` is 0. A load with any select inactive starts nothing and ends a running burst.
- R6: Accesses already in the pipeline complete even if the chip is deselected afterwards.
- R7: `dataDrive` goes low after the second enabled edge following a deselecting load or a write start, unless a later read fills that slot.
- R8: `outEnN` high forces `dataDrive` low at once, without any clock, and does not disturb the pipeline.
- R9: When `advanceNotLoad` is 1 after a selected load, the block starts a further access of the loaded type, with byte enables taken from the current cycle. Its address keeps the upper bits of the loaded address. The low two bits are (base + n) mod 4 when `linearOrder` was 1 at the load, and base XOR n otherwise. Here n counts advances modulo 4.
- R10: `advanceNotLoad` at 1 with no burst running (after reset or a deselecting load) starts no access.
- R11: After reset, no access is pending and `dataDrive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| readNotWrite | input | 1 | 1 = read, 0 = write, taken at a load |
| advanceNotLoad | input | 1 | 0 = load new address, 1 = advance burst |
| linearOrder | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| laneWrN | input | LANES | Active-low byte-lane write enables |
| addrIn | input | AW | Word address |
| dataIn | input | DW | Write data side of the bus |
| outEnN | input | 1 | Asynchronous active-low output enable |
| dataOut | output | DW | Read data side of the bus |
| dataDrive | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The critical coincidence is a write committing its data at the same edge at which a read of the same word enters the pipeline or sits one stage behind it. The bench provokes this by alternating reads and writes on every cycle over a small address set. It does the same with freezing clock-enable cycles and with bursts. Every read value is judged against a behavioural model that commits writes in enabled-edge order. A second coincidence, `outEnN` pulled high while a read is in flight, is judged by the drive enable dropping and then returning while the pipeline keeps advancing.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  typedef struct packed {
    logic step;
    logic doWrite;
    logic doRead;
  } dpStrobes_t;

  function automatic logic [1:0] burstOffset(input logic [1:0] base,
                                             input logic [1:0] count,
                                             input logic       linear);
    return linear ? (base + count) : (base ^ count);
  endfunction

endpackage

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic             selAN,
  input  logic             selB,
  input  logic             selCN,
  input  logic             readNotWrite,
  input  logic             advanceNotLoad,
  input  logic             linearOrder,
  input  logic [LANES-1:0] laneWrN,
  input  logic [AW-1:0]    addrIn,
  output dpStrobes_t       strb,
  output logic [AW-1:0]    opAddr,
  output logic [LANES-1:0] opLanes,
  output logic             stage1Busy
);

  typedef struct packed {
    logic             valid;
    logic             write;
    logic [AW-1:0]    addr;
    logic [LANES-1:0] lanes;
  } stage_t;

  stage_t stageA, stageB, stageANext;

  logic          burstOn, burstOnNext;
  logic          burstWrite, burstWriteNext;
  logic          burstLinear, burstLinearNext;
  logic [AW-1:0] burstBase, burstBaseNext;
  logic [1:0]    burstCnt, burstCntNext;
  logic          chipSel;

  assign chipSel = ~selAN & selB & ~selCN;

  always_comb begin
    stageANext      = '0;
    burstOnNext     = burstOn;
    burstWriteNext  = burstWrite;
    burstLinearNext = burstLinear;
    burstBaseNext   = burstBase;
    burstCntNext    = burstCnt;
    if (!advanceNotLoad) begin
      if (chipSel) begin
        stageANext.valid = 1'b1;
        stageANext.write = ~readNotWrite;
        stageANext.addr  = addrIn;
        stageANext.lanes = ~laneWrN;
        burstOnNext      = 1'b1;
        burstWriteNext   = ~readNotWrite;
        burstLinearNext  = linearOrder;
        burstBaseNext    = addrIn;
        burstCntNext     = 2'd0;
      end else begin
        burstOnNext = 1'b0;
      end
    end else if (burstOn) begin
      burstCntNext     = burstCnt + 2'd1;
      stageANext.valid = 1'b1;
      stageANext.write = burstWrite;
      stageANext.addr  = {burstBase[AW-1:2],
                          burstOffset(burstBase[1:0], burstCnt + 2'd1, burstLinear)};
      stageANext.lanes = ~laneWrN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA      <= '0;
      stageB      <= '0;
      burstOn     <= 1'b0;
      burstWrite  <= 1'b0;
      burstLinear <= 1'b0;
      burstBase   <= '0;
      burstCnt    <= 2'd0;
    end else if (!clkEnN) begin
      stageA      <= stageANext;
      stageB      <= stageA;
      burstOn     <= burstOnNext;
      burstWrite  <= burstWriteNext;
      burstLinear <= burstLinearNext;
      burstBase   <= burstBaseNext;
      burstCnt    <= burstCntNext;
    end
  end

  assign strb.step    = ~clkEnN;
  assign strb.doWrite = stageB.valid & stageB.write;
  assign strb.doRead  = stageB.valid & ~stageB.write;
  assign opAddr       = stageB.addr;
  assign opLanes      = stageB.lanes;
  assign stage1Busy   = stageA.valid;

endmodule

// File: rtl/zbt_sram_dp.sv
module zbt_sram_dp
  import zbt_sram_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(WORDS),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  input  logic [AW-1:0]    opAddr,
  input  logic [LANES-1:0] opLanes,
  input  logic [DW-1:0]    dataIn,
  input  logic             outEnN,
  output logic [DW-1:0]    dataOut,
  output logic             dataDrive
);

  logic [DW-1:0] readWord;
  logic [DW-1:0] outReg;
  logic          driveReg;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [WORDS];

    always_ff @(posedge clk) begin
      if (strb.step && strb.doWrite && opLanes[g])
        bank[opAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    assign readWord[g*LANE_W +: LANE_W] = bank[opAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveReg <= 1'b0;
      outReg   <= '0;
    end else if (strb.step) begin
      driveReg <= strb.doRead;
      if (strb.doRead) outReg <= readWord;
    end
  end

  assign dataOut   = outReg;
  assign dataDrive = driveReg & ~outEnN;

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(WORDS),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic             selAN,
  input  logic             selB,
  input  logic             selCN,
  input  logic             readNotWrite,
  input  logic             advanceNotLoad,
  input  logic             linearOrder,
  input  logic [LANES-1:0] laneWrN,
  input  logic [AW-1:0]    addrIn,
  input  logic [DW-1:0]    dataIn,
  input  logic             outEnN,
  output logic [DW-1:0]    dataOut,
  output logic             dataDrive
);

  dpStrobes_t       strb;
  logic [AW-1:0]    opAddr;
  logic [LANES-1:0] opLanes;
  logic             stage1Busy;

  zbt_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .selAN(selAN), .selB(selB), .selCN(selCN),
    .readNotWrite(readNotWrite), .advanceNotLoad(advanceNotLoad),
    .linearOrder(linearOrder), .laneWrN(laneWrN), .addrIn(addrIn),
    .strb(strb), .opAddr(opAddr), .opLanes(opLanes), .stage1Busy(stage1Busy)
  );

  zbt_sram_dp #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opLanes(opLanes),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut), .dataDrive(dataDrive)
  );

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
  import zbt_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rstN,
  input logic          clkEnN,
  input logic          advanceNotLoad,
  input logic          selAN,
  input logic          selB,
  input logic          selCN,
  input logic          outEnN,
  input logic [DW-1:0] dataOut,
  input logic          dataDrive,
  input dpStrobes_t    strb,
  input logic          stage1Busy
);

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.doRead) |=> (dataDrive || outEnN));

  assert_freeze_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dataOut));

  assert_deselect_no_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advanceNotLoad && !(!selAN && selB && !selCN)) |=> !stage1Busy);

  assert_inflight_completes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && stage1Busy) |=> (strb.doRead || strb.doWrite));

  assert_write_releases_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.doWrite) |=> !dataDrive);

endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advanceNotLoad(advanceNotLoad),
  .selAN(selAN), .selB(selB), .selCN(selCN), .outEnN(outEnN),
  .dataOut(dataOut), .dataDrive(dataDrive), .strb(strb), .stage1Busy(stage1Busy)
);

// File: tb/tb_zbt_sram.sv
`timescale 1ns/100ps
module tb_zbt_sram;
  localparam int WORDS = 64, LANES = 4, LANE_W = 9;
  localparam int AW = $clog2(WORDS), DW = LANES * LANE_W;

  logic clk = 1'b0, rstN = 1'b0, clkEnN = 1'b0;
  logic selAN = 1'b1, selB = 1'b0, selCN = 1'b1;
  logic readNotWrite = 1'b1, advanceNotLoad = 1'b0, linearOrder = 1'b1;
  logic [LANES-1:0] laneWrN = '1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic outEnN = 1'b0;
  logic [DW-1:0] dataOut;
  logic dataDrive;

  zbt_sram dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string curReq = "R11";
  bit running = 0;

  typedef struct {
    bit wr;
    int addr;
    bit [LANES-1:0] lanes;
    longint due;
  } op_t;

  op_t pend[$];
  logic [DW-1:0] refMem [WORDS];
  logic [DW-1:0] expOut = '0;
  bit expDrive = 0;
  longint edgeNo = 0;
  bit bOn = 0, bWr = 0, bLin = 0;
  int bBase = 0, bCnt = 0;

  // Behavioural reference: accesses queued with their due enabled-edge number
  always @(posedge clk) begin
    if (!rstN) begin
      pend.delete(); expDrive = 0; bOn = 0; edgeNo = 0;
    end else if (!clkEnN) begin
      bit nd;
      edgeNo++;
      nd = 0;
      if (pend.size() > 0 && pend[0].due == edgeNo) begin
        op_t o;
        o = pend.pop_front();
        if (o.wr) begin
          for (int k = 0; k < LANES; k++)
            if (o.lanes[k]) refMem[o.addr][k*LANE_W +: LANE_W] = dataIn[k*LANE_W +: LANE_W];
        end else begin
          expOut = refMem[o.addr];
          nd = 1;
        end
      end
      expDrive = nd;
      if (!advanceNotLoad) begin
        if (!selAN && selB && !selCN) begin
          op_t n;
          n.wr = !readNotWrite; n.addr = int'(addrIn); n.lanes = ~laneWrN; n.due = edgeNo + 2;
          pend.push_back(n);
          bOn = 1; bWr = !readNotWrite; bLin = linearOrder; bBase = int'(addrIn); bCnt = 0;
        end else bOn = 0;
      end else if (bOn) begin
        op_t n;
        int lo;
        bCnt = (bCnt + 1) % 4;
        lo = bLin ? ((bBase + bCnt) % 4) : ((bBase % 4) ^ bCnt);
        n.wr = bWr; n.addr = (bBase / 4) * 4 + lo; n.lanes = ~laneWrN; n.due = edgeNo + 2;
        pend.push_back(n);
      end
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      bit ed;
      ed = expDrive && !outEnN;
      checks++;
      if (dataDrive !== ed) begin
        errors++;
        $display("FAIL %s: dataDrive=%b expected %b at %0t", curReq, dataDrive, ed, $time);
      end
      if (ed) begin
        checks++;
        if (dataOut !== expOut) begin
          errors++;
          $display("FAIL %s: dataOut=%h expected %h at %0t", curReq, dataOut, expOut, $time);
        end
      end
    end
  end

  task automatic cyc(bit enOff, bit adv, bit [2:0] sel, bit rd, bit lin,
                     int a, bit [LANES-1:0] lw, bit oe);
    @(negedge clk); #1;
    clkEnN = enOff; advanceNotLoad = adv;
    selAN = ~sel[0]; selB = sel[1]; selCN = ~sel[2];
    readNotWrite = rd; linearOrder = lin; addrIn = AW'(a); laneWrN = lw; outEnN = oe;
    dataIn = {$urandom(), $urandom()};
  endtask

  function automatic bit pct(int p);
    return $urandom_range(0, 99) < p;
  endfunction

  task automatic randCyc(int offP, int advP, int deselP, int oeP, int rdP, int addrMax);
    bit [2:0] s;
    s = 3'b111;
    if (pct(deselP)) s[$urandom_range(0, 2)] = 1'b0;
    cyc(pct(offP), pct(advP), s, pct(rdP), pct(50), $urandom_range(0, addrMax),
        LANES'($urandom()), pct(oeP));
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung, expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rstN = 1'b1;
    // R11: nothing pending after reset, bus released
    repeat (2) begin
      @(negedge clk);
      checks++;
      if (dataDrive !== 1'b0) begin
        errors++;
        $display("FAIL R11: dataDrive=%b expected 0", dataDrive);
      end
    end
    running = 1;
    // R10: advance with no burst running starts nothing
    curReq = "R10";
    repeat (6) cyc(0, 1, 3'b111, 1, 1, 5, '0, 0);
    // R2: fill every word with full lanes, then partial-lane writes
    curReq = "R2";
    for (int i = 0; i < WORDS; i++) cyc(0, 0, 3'b111, 0, 1, i, '0, 0);
    repeat (150) cyc(0, 0, 3'b111, 0, 1, $urandom_range(0, 7), LANES'($urandom()), 0);
    // R1: plain reads of all words
    curReq = "R1";
    for (int i = 0; i < WORDS; i++) cyc(0, 0, 3'b111, 1, 1, i, '1, 0);
    // R3: read/write alternation on every cycle over a few words
    curReq = "R3";
    for (int i = 0; i < 400; i++) cyc(0, 0, 3'b111, i[0], 1, $urandom_range(0, 3), LANES'($urandom()), 0);
    // R4: clock enable freezing mid-pipeline
    curReq = "R4";
    repeat (400) randCyc(35, 20, 0, 0, 50, 7);
    // R5/R6/R7: deselecting loads behind pending reads and writes
    curReq = "R5";
    repeat (300) randCyc(0, 10, 50, 0, 50, 7);
    curReq = "R6";
    for (int i = 0; i < 60; i++) begin
      cyc(0, 0, 3'b111, i[0], 1, i % 8, '0, 0);
      cyc(0, 0, 3'b011, 1, 1, 0, '0, 0);
      cyc(0, 0, 3'b101, 1, 1, 0, '0, 0);
    end
    curReq = "R7";
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 3'b111, 1, 1, i % 8, '1, 0);
      cyc(0, 0, 3'b111, 0, 1, i % 8, '0, 0);
      cyc(0, 0, 3'b110, 1, 1, 0, '0, 0);
      cyc(0, 0, 3'b111, 1, 1, i % 8, '1, 0);
    end
    // R9: bursts of both orders and types, running past four to wrap
    curReq = "R9";
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 3'b111, i[1], i[0], $urandom_range(0, WORDS - 1), '0, 0);
      repeat ($urandom_range(1, 7)) cyc(pct(15), 1, 3'b111, 1, 1, 0, LANES'($urandom()), 0);
    end
    // R10: advance after a deselecting load
    curReq = "R10";
    for (int i = 0; i < 20; i++) begin
      cyc(0, 0, 3'b111, 1, 1, i, '1, 0);
      cyc(0, 0, 3'b100, 1, 1, 0, '1, 0);
      repeat (4) cyc(0, 1, 3'b111, 1, 1, 0, '1, 0);
    end
    // R8: asynchronous output enable, including a mid-cycle change
    curReq = "R8";
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 3'b111, 1, 1, i % 16, '1, 0);
      cyc(0, 0, 3'b111, 1, 1, i % 16, '1, 0);
      #0.5 outEnN = 1'b1;
      #0.2;
      checks++;
      if (dataDrive !== 1'b0) begin
        errors++;
        $display("FAIL R8: dataDrive=%b expected 0 with outEnN high", dataDrive);
      end
    end
    repeat (300) randCyc(10, 30, 10, 40, 50, 15);
    // Mixed traffic across all functions
    curReq = "R3";
    repeat (2000) randCyc(15, 35, 15, 10, 50, WORDS - 1);
    repeat (4) cyc(0, 0, 3'b000, 1, 1, 0, '1, 0);
    running = 0;
    finishRun();
  end
endmodule